// File: doc/BRIEF.md
# PS/2 Held-Key Decoder

This block listens to a PS/2 keyboard on its clock and data lines and turns the stream of scan codes into two level outputs, `up_o` and `down_o`. Each output is high for exactly as long as its key is physically pressed. It is meant for simple game or control logic that needs button-like behaviour from a keyboard.

Both lines are first brought into the system clock domain through a synchroniser chain. A frame receiver then samples the data line on each falling edge of the synchronised keyboard clock. It checks framing and odd parity and hands each good byte to a key tracker. The tracker follows three kinds of sequence: make codes, the repeated make codes sent while a key is held, and release sequences that start with a break prefix. An extended-key prefix is tracked only so that extended keys are never mistaken for a mapped key.

Top module: `ps2_hold_keys`

## Requirements
- R1: After a synchronous reset, `up_o` and `down_o` are both 0.
- R2: A received byte 0x15 with no pending prefix drives `up_o` to 1. A received byte 0x1C with no pending prefix drives `down_o` to 1.
- R3: Repeated make codes for a key that is already held leave its output at 1, with no glitch to 0.
- R4: The byte 0xF0 followed by a mapped code clears only that code's output.
- R5: The byte 0xE0 marks the next code as extended. An extended code changes neither output, whether it is a make code or a 0xF0 release. The mark is dropped after that one code.
- R6: A byte that is not a mapped code leaves both outputs unchanged. A 0xF0 followed by such a byte also leaves both outputs unchanged, and it consumes the pending release.
- R7: A frame has 11 bits, each sampled on a falling edge of the keyboard clock. The bits are a start bit of 0, 8 data bits sent least significant bit first, an odd-parity bit, and a stop bit of 1.
- R8: A frame with wrong parity, or with a stop bit of 0, is discarded and has no effect on either output.
- R9: If the keyboard clock stays high for more than `TIMEOUT_CYC` system cycles in the middle of a frame, the partial frame is discarded. The receiver then waits for a new start bit.
- R10: A reset also clears a pending release and a pending extended mark, so the next make code after reset takes effect.
- R11: The two outputs are independent. Both can be high at the same time, and each follows its own make and release codes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| kb_clk_i | input | 1 | Keyboard clock line, asynchronous, idles high |
| kb_dat_i | input | 1 | Keyboard data line, asynchronous, idles high |
| up_o | output | 1 | High while the key mapped to 0x15 is held |
| down_o | output | 1 | High while the key mapped to 0x1C is held |

## Verification
The bench sends plain make/release pairs and overlapping presses of both keys. Overlapping presses show that the keys are independent rather than sharing a last-byte latch. Runs of repeated make codes confirm that repeats never toggle an output. Extended prefixes, with and without a release, and unmapped codes after a release prefix check that each prefix lasts for one code only. Frames with bad parity or a bad stop bit, a truncated frame followed by a long idle, and a reset in the middle of a prefix check that damaged or interrupted input never leaves stale receiver state or stale flags.

// File: rtl/ps2hk_pkg.sv
package ps2hk_pkg;
   localparam logic [7:0] CODE_BREAK = 8'hF0;
   localparam logic [7:0] CODE_EXT   = 8'hE0;

   typedef enum logic [1:0] {
      RX_IDLE,
      RX_DATA,
      RX_PAR,
      RX_STOP
   } rx_state_e;
endpackage

// File: rtl/ps2hk_sync.sv
module ps2hk_sync #(
   parameter int unsigned W      = 2,
   parameter int unsigned STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("ps2hk_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (rst) stg[0] <= RST_VAL;
            else     stg[0] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (rst) stg[s] <= RST_VAL;
            else     stg[s] <= stg[s-1];
         end
      end
   end

   assign q_o = stg[STAGES-1];
endmodule

// File: rtl/ps2hk_frame_rx.sv
module ps2hk_frame_rx
   import ps2hk_pkg::*;
#(
   parameter int unsigned TIMEOUT_CYC = 5000
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       kclk_i,
   input  logic       kdat_i,
   output logic       byte_vld_o,
   output logic [7:0] byte_o
);
   localparam int unsigned TW = $clog2(TIMEOUT_CYC + 1);
   localparam logic [TW-1:0] TMO_LAST = TW'(TIMEOUT_CYC);

   if (TIMEOUT_CYC < 4) begin : g_bad_tmo
      $error("ps2hk_frame_rx: TIMEOUT_CYC too small");
   end

   rx_state_e     state_q;
   logic          kclk_d;
   logic          fall;
   logic [2:0]    idx_q;
   logic [7:0]    shreg_q;
   logic          par_q;
   logic [TW-1:0] tmo_q;
   logic          vld_q;
   logic [7:0]    byte_q;

   assign fall = kclk_d & ~kclk_i;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= RX_IDLE;
         kclk_d  <= 1'b1;
         idx_q   <= '0;
         shreg_q <= '0;
         par_q   <= 1'b0;
         tmo_q   <= '0;
         vld_q   <= 1'b0;
         byte_q  <= '0;
      end else begin
         kclk_d <= kclk_i;
         vld_q  <= 1'b0;
         if (fall) begin
            tmo_q <= '0;
            unique case (state_q)
               RX_IDLE: begin
                  if (!kdat_i) begin
                     state_q <= RX_DATA;
                     idx_q   <= '0;
                  end
               end
               RX_DATA: begin
                  shreg_q <= {kdat_i, shreg_q[7:1]};
                  idx_q   <= idx_q + 3'd1;
                  if (idx_q == 3'd7) state_q <= RX_PAR;
               end
               RX_PAR: begin
                  par_q   <= kdat_i;
                  state_q <= RX_STOP;
               end
               RX_STOP: begin
                  if (kdat_i && (^{shreg_q, par_q})) begin
                     vld_q  <= 1'b1;
                     byte_q <= shreg_q;
                  end
                  state_q <= RX_IDLE;
               end
               default: state_q <= RX_IDLE;
            endcase
         end else if (state_q != RX_IDLE && kclk_i) begin
            if (tmo_q == TMO_LAST) begin
               state_q <= RX_IDLE;
               tmo_q   <= '0;
            end else begin
               tmo_q <= tmo_q + 1'b1;
            end
         end else begin
            tmo_q <= '0;
         end
      end
   end

   assign byte_vld_o = vld_q;
   assign byte_o     = byte_q;

   // R7
   stop_sampled_chk: assert property (@(posedge clk) disable iff (rst)
      vld_q |-> ($past(fall) && $past(kdat_i)));

   // R9
   tmo_bound_chk: assert property (@(posedge clk) disable iff (rst)
      tmo_q <= TMO_LAST);

   // R9
   tmo_abort_chk: assert property (@(posedge clk) disable iff (rst)
      (tmo_q == TMO_LAST && !fall && kclk_i && state_q != RX_IDLE) |=> state_q == RX_IDLE);
endmodule

// File: rtl/ps2hk_key_track.sv
module ps2hk_key_track
   import ps2hk_pkg::*;
#(
   parameter int unsigned NKEYS = 2,
   parameter logic [NKEYS*8-1:0] KEY_CODES = {8'h1C, 8'h15}
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             byte_vld_i,
   input  logic [7:0]       byte_i,
   output logic [NKEYS-1:0] held_o
);
   logic brk_q;
   logic ext_q;
   logic is_brk;
   logic is_ext;

   assign is_brk = (byte_i == CODE_BREAK);
   assign is_ext = (byte_i == CODE_EXT);

   always_ff @(posedge clk) begin
      if (rst) begin
         brk_q <= 1'b0;
         ext_q <= 1'b0;
      end else if (byte_vld_i) begin
         if (is_brk) begin
            brk_q <= 1'b1;
         end else if (is_ext) begin
            ext_q <= 1'b1;
         end else begin
            brk_q <= 1'b0;
            ext_q <= 1'b0;
         end
      end
   end

   for (genvar k = 0; k < NKEYS; k++) begin : g_key
      localparam logic [7:0] CODE = KEY_CODES[k*8 +: 8];

      if (CODE == CODE_BREAK || CODE == CODE_EXT) begin : g_bad_code
         $error("ps2hk_key_track: key code collides with a prefix");
      end

      always_ff @(posedge clk) begin
         if (rst) begin
            held_o[k] <= 1'b0;
         end else if (byte_vld_i && !ext_q && byte_i == CODE) begin
            held_o[k] <= ~brk_q;
         end
      end

      // R2
      make_set_chk: assert property (@(posedge clk) disable iff (rst)
         (byte_vld_i && byte_i == CODE && !brk_q && !ext_q) |=> held_o[k]);

      // R4
      brk_clear_chk: assert property (@(posedge clk) disable iff (rst)
         (byte_vld_i && byte_i == CODE && brk_q && !ext_q) |=> !held_o[k]);

      // R5
      ext_ignore_chk: assert property (@(posedge clk) disable iff (rst)
         (byte_vld_i && ext_q) |=> $stable(held_o[k]));

      // R6
      idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
         (!byte_vld_i || byte_i != CODE) |=> $stable(held_o[k]));
   end
endmodule

// File: rtl/ps2_hold_keys.sv
module ps2_hold_keys #(
   parameter int unsigned TIMEOUT_CYC = 5000,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [7:0]  UP_CODE     = 8'h15,
   parameter logic [7:0]  DOWN_CODE   = 8'h1C
) (
   input  logic clk,
   input  logic rst,
   input  logic kb_clk_i,
   input  logic kb_dat_i,
   output logic up_o,
   output logic down_o
);
   localparam int unsigned NKEYS = 2;

   if (UP_CODE == DOWN_CODE) begin : g_bad_map
      $error("ps2_hold_keys: UP_CODE and DOWN_CODE must differ");
   end

   logic [1:0]       lines_s;
   logic             byte_vld;
   logic [7:0]       rx_byte;
   logic [NKEYS-1:0] held;

   ps2hk_sync #(
      .W       (2),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (2'b11)
   ) u_sync (
      .clk (clk),
      .rst (rst),
      .d_i ({kb_dat_i, kb_clk_i}),
      .q_o (lines_s)
   );

   ps2hk_frame_rx #(
      .TIMEOUT_CYC (TIMEOUT_CYC)
   ) u_rx (
      .clk        (clk),
      .rst        (rst),
      .kclk_i     (lines_s[0]),
      .kdat_i     (lines_s[1]),
      .byte_vld_o (byte_vld),
      .byte_o     (rx_byte)
   );

   ps2hk_key_track #(
      .NKEYS     (NKEYS),
      .KEY_CODES ({DOWN_CODE, UP_CODE})
   ) u_keys (
      .clk        (clk),
      .rst        (rst),
      .byte_vld_i (byte_vld),
      .byte_i     (rx_byte),
      .held_o     (held)
   );

   assign up_o   = held[0];
   assign down_o = held[1];

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (!up_o && !down_o));
endmodule

// File: tb/ps2_hold_keys_tb.sv
module ps2_hold_keys_tb;
   localparam int CLK_PERIOD = 10;
   localparam int HALF_BIT   = 20;
   localparam int TMO        = 5000;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic kclk = 1'b1;
   logic kdat = 1'b1;
   logic up_o, down_o;

   int checks = 0;
   int errors = 0;
   int mask = 0;
   bit done = 0;

   bit exp_up = 0, exp_dn = 0, m_brk = 0, m_ext = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ps2_hold_keys #(.TIMEOUT_CYC(TMO)) u_dut (
      .clk      (clk),
      .rst      (rst),
      .kb_clk_i (kclk),
      .kb_dat_i (kdat),
      .up_o     (up_o),
      .down_o   (down_o)
   );

   task automatic model_byte(input logic [7:0] b);
      if (b == 8'hF0) m_brk = 1;
      else if (b == 8'hE0) m_ext = 1;
      else begin
         if (!m_ext) begin
            if (b == 8'h15) exp_up = !m_brk;
            if (b == 8'h1C) exp_dn = !m_brk;
         end
         m_brk = 0;
         m_ext = 0;
      end
   endtask

   // continuous reference comparison (R11: keys tracked independently)
   always @(negedge clk) begin
      if (!rst && !done) begin
         if (mask > 0) mask--;
         else begin
            checks++;
            if (up_o !== exp_up || down_o !== exp_dn) begin
               errors++;
               $display("FAIL R11 model compare: up=%0b down=%0b expected up=%0b down=%0b",
                        up_o, down_o, exp_up, exp_dn);
            end
         end
      end
   end

   task automatic do_reset();
      rst = 1;
      exp_up = 0; exp_dn = 0; m_brk = 0; m_ext = 0;
      repeat (4) @(negedge clk);
      rst = 0;
      repeat (4) @(negedge clk);
   endtask

   task automatic send_frame(input logic [7:0] b, input bit bad_par = 0, input bit bad_stop = 0);
      logic [10:0] bits;
      bits = {~bad_stop, (~^b) ^ bad_par, b, 1'b0};
      for (int i = 0; i < 11; i++) begin
         kdat = bits[i];
         repeat (HALF_BIT) @(negedge clk);
         kclk = 0;
         if (i == 10 && !bad_par && !bad_stop) begin
            model_byte(b);
            mask = 12;
         end
         repeat (HALF_BIT) @(negedge clk);
         kclk = 1;
      end
      kdat = 1;
      repeat (3*HALF_BIT) @(negedge clk);
   endtask

   task automatic send_partial(input logic [7:0] b, input int nbits);
      logic [10:0] bits;
      bits = {1'b1, ~^b, b, 1'b0};
      for (int i = 0; i < nbits; i++) begin
         kdat = bits[i];
         repeat (HALF_BIT) @(negedge clk);
         kclk = 0;
         repeat (HALF_BIT) @(negedge clk);
         kclk = 1;
      end
      kdat = 1;
   endtask

   task automatic chk(input string tag, input bit eu, input bit ed);
      checks++;
      if (up_o !== eu || down_o !== ed) begin
         errors++;
         $display("FAIL %s: up=%0b down=%0b expected up=%0b down=%0b",
                  tag, up_o, down_o, eu, ed);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      do_reset();
      chk("R1 reset state", 0, 0);

      send_frame(8'h15);
      chk("R2 up make", 1, 0);
      chk("R7 lsb-first framing", 1, 0);
      send_frame(8'h15);
      send_frame(8'h15);
      chk("R3 repeat keeps up", 1, 0);
      send_frame(8'h1C);
      chk("R11 both held", 1, 1);
      send_frame(8'h1C);
      chk("R3 repeat keeps down", 1, 1);

      send_frame(8'hF0); send_frame(8'h15);
      chk("R4 release up only", 0, 1);
      send_frame(8'hF0); send_frame(8'h1C);
      chk("R4 release down", 0, 0);

      send_frame(8'h2A);
      chk("R6 unmapped make", 0, 0);
      send_frame(8'h15);
      send_frame(8'hF0); send_frame(8'h2A);
      chk("R6 unmapped release keeps up", 1, 0);
      send_frame(8'h1C);
      chk("R6 release prefix consumed", 1, 1);
      send_frame(8'hF0); send_frame(8'h15);
      send_frame(8'hF0); send_frame(8'h1C);
      chk("R4 both released", 0, 0);

      send_frame(8'hE0); send_frame(8'h15);
      chk("R5 extended make ignored", 0, 0);
      send_frame(8'h15);
      chk("R5 mark lasts one code", 1, 0);
      send_frame(8'hE0); send_frame(8'hF0); send_frame(8'h15);
      chk("R5 extended release ignored", 1, 0);
      send_frame(8'hF0); send_frame(8'h15);
      chk("R4 plain release after extended", 0, 0);

      send_frame(8'h15, 1, 0);
      chk("R8 bad parity dropped", 0, 0);
      send_frame(8'h1C, 0, 1);
      chk("R8 bad stop dropped", 0, 0);
      send_frame(8'h1C);
      chk("R8 recovery after bad frames", 0, 1);
      send_frame(8'hF0); send_frame(8'h1C);

      send_partial(8'h15, 4);
      repeat (TMO + 1000) @(negedge clk);
      send_frame(8'h1C);
      chk("R9 partial frame abandoned", 0, 1);
      send_frame(8'hF0); send_frame(8'h1C);
      chk("R9 release after timeout", 0, 0);

      send_frame(8'h15);
      do_reset();
      chk("R1 reset clears held key", 0, 0);
      send_frame(8'hF0);
      do_reset();
      send_frame(8'h15);
      chk("R10 reset drops release", 1, 0);
      send_frame(8'hE0);
      do_reset();
      send_frame(8'h1C);
      chk("R10 reset drops extended", 0, 1);

      repeat (20) @(negedge clk);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule